// File: doc/BRIEF.md
# Two-Bank Memory with Shifting Spare-Row Repair

A behavioural 128-word by 32-bit single-port memory with no column multiplexing. It is split into two banks of 64 rows each. Address bit 5 picks the bank, and the other six address bits form the row index within that bank. Each bank carries one extra physical row at index 64. Each bank also has its own fuse word, made of a 6-bit faulty-row index and an enable bit.

When a bank's repair is enabled, the faulty row and every row above it in that bank move up by one physical position. The top logical row of the bank therefore lands on the spare. The faulty physical row is never touched again. The fuse words are captured from their inputs on a load strobe, normally issued once after reset. Reads return data one cycle after the request.

Top module: `shift_row_ram`

## Requirements
- R1: While `rst_ni` is low, `rdata_o` is zero, both fuse enables are cleared, and every storage row, spare rows included, is cleared to zero.
- R2: `addr_i[5]` selects the bank: 0 selects the top bank and 1 selects the bottom bank. The in-bank row index is `{addr_i[6], addr_i[4:0]}`. The top bank therefore holds addresses 0–31 and 64–95, and the bottom bank holds 32–63 and 96–127.
- R3: A read (`ce_i`=1, `we_i`=0) presents its word on `rdata_o` after the next rising clock edge. In any cycle without a read, `rdata_o` holds its value.
- R4: With a bank's captured enable low, in-bank index i uses physical row i, so the spare is unused.
- R5: With a bank's captured enable high and fused index f, any in-bank index i < f uses physical row i.
- R6: With a bank's captured enable high, any in-bank index i ≥ f uses physical row i+1. Index 63 therefore uses the spare row 64.
- R7: While a bank's repair is enabled, physical row f of that bank is never read or written, so it keeps its earlier contents.
- R8: The two banks' repairs are independent. A fuse on one bank leaves the mapping of the other bank unchanged.
- R9: Fuse inputs are captured only in a cycle with `fuse_load_i` high. Changes on the fuse inputs at other times have no effect.
- R10: A cycle with `ce_i` low neither writes nor reads, whatever the values of `we_i`, `addr_i` and `wdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fuse_load_i | input | 1 | Capture strobe for both fuse words |
| top_fuse_addr_i | input | 6 | Faulty in-bank row index, top bank |
| top_fuse_en_i | input | 1 | Repair enable, top bank |
| bot_fuse_addr_i | input | 6 | Faulty in-bank row index, bottom bank |
| bot_fuse_en_i | input | 1 | Repair enable, bottom bank |
| ce_i | input | 1 | Chip enable |
| we_i | input | 1 | Write enable (1 = write, 0 = read) |
| addr_i | input | 7 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. A read's word appears after the edge that follows the request, a write lands at that same edge, and a fuse strobe changes the mapping from the next edge onward. Each bench task drives its stimulus at a falling edge and samples `rdata_o` at the following falling edge, half a cycle after the edge that produced the result. Remapping is observed at the ports by writing data under one fuse setting and reading it back under another, so every shift appears as a predictable neighbouring word, or as zero from a spare that was never written.

// File: rtl/srr_pkg.sv
package srr_pkg;
  localparam int unsigned NUM_BANKS = 2;

  typedef enum logic {
    BANK_TOP = 1'b0,
    BANK_BOT = 1'b1
  } bank_e;
endpackage

// File: rtl/srr_fuse_latch.sv
module srr_fuse_latch #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             en_i,
  input  logic [IDX_W-1:0] addr_i,
  output logic             en_o,
  output logic [IDX_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      addr_o <= '0;
    end else if (load_i) begin
      en_o   <= en_i;
      addr_o <= addr_i;
    end
  end
endmodule

// File: rtl/srr_row_remap.sv
module srr_row_remap #(
  parameter int unsigned IDX_W = 6,
  localparam int unsigned PHYS_W = IDX_W + 1
) (
  input  logic              fuse_en_i,
  input  logic [IDX_W-1:0]  fuse_addr_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [PHYS_W-1:0] phys_o
);
  logic shift;
  assign shift  = fuse_en_i && (idx_i >= fuse_addr_i);
  assign phys_o = {1'b0, idx_i} + {{(PHYS_W-1){1'b0}}, shift};
endmodule

// File: rtl/srr_bank_array.sv
module srr_bank_array #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 6,
  localparam int unsigned PHYS_W = IDX_W + 1,
  localparam int unsigned ROWS   = (1 << IDX_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PHYS_W-1:0] phys_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
    end else if (we_i) begin
      mem_q[phys_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[phys_i];
endmodule

// File: rtl/shift_row_ram.sv
module shift_row_ram
  import srr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fuse_load_i,
  input  logic [ADDR_W-2:0] top_fuse_addr_i,
  input  logic              top_fuse_en_i,
  input  logic [ADDR_W-2:0] bot_fuse_addr_i,
  input  logic              bot_fuse_en_i,
  input  logic              ce_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned IDX_W    = ADDR_W - 1;
  localparam int unsigned PHYS_W   = IDX_W + 1;
  localparam int unsigned BANK_BIT = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  bank_e            bank_sel;
  assign idx      = {addr_i[ADDR_W-1], addr_i[BANK_BIT-1:0]};
  assign bank_sel = bank_e'(addr_i[BANK_BIT]);

  logic [NUM_BANKS-1:0]             fuse_raw_en;
  logic [NUM_BANKS-1:0][IDX_W-1:0]  fuse_raw_addr;
  logic [NUM_BANKS-1:0]             fuse_en_q;
  logic [NUM_BANKS-1:0][IDX_W-1:0]  fuse_addr_q;
  logic [NUM_BANKS-1:0][PHYS_W-1:0] phys_idx;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rd;

  assign fuse_raw_en[BANK_TOP]   = top_fuse_en_i;
  assign fuse_raw_addr[BANK_TOP] = top_fuse_addr_i;
  assign fuse_raw_en[BANK_BOT]   = bot_fuse_en_i;
  assign fuse_raw_addr[BANK_BOT] = bot_fuse_addr_i;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_we;
    assign bank_we = ce_i && we_i && (bank_sel == bank_e'(b));

    srr_fuse_latch #(.IDX_W(IDX_W)) u_fuse (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (fuse_load_i),
      .en_i   (fuse_raw_en[b]),
      .addr_i (fuse_raw_addr[b]),
      .en_o   (fuse_en_q[b]),
      .addr_o (fuse_addr_q[b])
    );

    srr_row_remap #(.IDX_W(IDX_W)) u_remap (
      .fuse_en_i   (fuse_en_q[b]),
      .fuse_addr_i (fuse_addr_q[b]),
      .idx_i       (idx),
      .phys_o      (phys_idx[b])
    );

    srr_bank_array #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_array (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (bank_we),
      .phys_i  (phys_idx[b]),
      .wdata_i (wdata_i),
      .rdata_o (bank_rd[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rdata_o <= '0;
    else if (ce_i && !we_i) rdata_o <= bank_rd[bank_sel];
  end
endmodule

// File: rtl/srr_chk.sv
module srr_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned IDX_W  = ADDR_W - 1,
  localparam int unsigned PHYS_W = IDX_W + 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  fuse_load_i,
  input logic                  ce_i,
  input logic                  we_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [DATA_W-1:0]     rdata_o,
  input logic [1:0]            fuse_en_q,
  input logic [1:0][IDX_W-1:0] fuse_addr_q,
  input logic [1:0][PHYS_W-1:0] phys_idx
);
  logic [IDX_W-1:0] idx;
  assign idx = {addr_i[ADDR_W-1], addr_i[ADDR_W-3:0]};

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r1: assert (rdata_o == '0 && fuse_en_q == 2'b00);
    end
  end

  p_rdata_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ce_i && !we_i) |=> $stable(rdata_o));

  p_fuse_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fuse_load_i |=> ($stable(fuse_en_q) && $stable(fuse_addr_q)));

  for (genvar b = 0; b < 2; b++) begin : g_chk
    p_direct_map_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fuse_en_q[b] |-> phys_idx[b] == {1'b0, idx});

    p_below_fault_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fuse_en_q[b] && idx < fuse_addr_q[b]) |-> phys_idx[b] == {1'b0, idx});

    p_shift_up_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fuse_en_q[b] && idx >= fuse_addr_q[b]) |-> phys_idx[b] > {1'b0, idx});

    p_skip_fault_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fuse_en_q[b] && ce_i && addr_i[ADDR_W-2] == b[0])
        |-> phys_idx[b] != {1'b0, fuse_addr_q[b]});
  end
endmodule

bind shift_row_ram srr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fuse_load_i (fuse_load_i),
  .ce_i        (ce_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .rdata_o     (rdata_o),
  .fuse_en_q   (fuse_en_q),
  .fuse_addr_q (fuse_addr_q),
  .phys_idx    (phys_idx)
);

// File: tb/shift_row_ram_tb.sv
`timescale 1ns/1ps
module shift_row_ram_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fuse_load_i = 1'b0;
  logic [5:0]  top_fuse_addr_i = '0;
  logic        top_fuse_en_i = 1'b0;
  logic [5:0]  bot_fuse_addr_i = '0;
  logic        bot_fuse_en_i = 1'b0;
  logic        ce_i = 1'b0;
  logic        we_i = 1'b0;
  logic [6:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;

  int vectors = 0;
  int errors  = 0;

  localparam logic [31:0] SALT0 = 32'h1234_0F0F;
  localparam logic [31:0] SALT1 = 32'hC0DE_5A00;

  always #5 clk_i = ~clk_i;

  shift_row_ram u_dut (
    .clk_i, .rst_ni, .fuse_load_i,
    .top_fuse_addr_i, .top_fuse_en_i, .bot_fuse_addr_i, .bot_fuse_en_i,
    .ce_i, .we_i, .addr_i, .wdata_i, .rdata_o
  );

  function automatic logic [31:0] pat(logic [31:0] salt, int a);
    return salt ^ (32'(a) * 32'h9E37_79B1);
  endfunction

  function automatic logic [6:0] mk(int bank, int idx);
    return {idx[5], bank[0], idx[4:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk_i);
    ce_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    ce_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk_i);
    ce_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    ce_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic load_fuse(logic ten, int ta, logic ben, int ba);
    @(negedge clk_i);
    top_fuse_en_i = ten; top_fuse_addr_i = ta[5:0];
    bot_fuse_en_i = ben; bot_fuse_addr_i = ba[5:0];
    fuse_load_i = 1'b1;
    @(negedge clk_i);
    fuse_load_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 rdata after reset", rdata_o, 32'h0);
    rd(7'd5, d);
    chk("R1 cleared row", d, 32'h0);
  endtask

  task automatic t_plain;
    logic [31:0] d;
    for (int a = 0; a < 128; a++) wr(a[6:0], pat(SALT0, a));
    for (int a = 0; a < 128; a++) begin
      rd(a[6:0], d);
      chk("R2/R4 direct map", d, pat(SALT0, a));
    end
  endtask

  task automatic t_latency;
    logic [31:0] d;
    rd(7'd33, d);
    chk("R3 one-cycle read", d, pat(SALT0, 33));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk("R3 hold idle", rdata_o, pat(SALT0, 33));
    end
    wr(7'd90, pat(SALT0, 90));
    chk("R3 hold on write", rdata_o, pat(SALT0, 33));
  endtask

  task automatic t_ce_ignored;
    logic [31:0] d;
    @(negedge clk_i);
    ce_i = 1'b0; we_i = 1'b1; addr_i = 7'd7; wdata_i = 32'hDEAD_BEEF;
    @(negedge clk_i);
    chk("R10 no read when ce low", rdata_o, pat(SALT0, 33));
    we_i = 1'b0;
    rd(7'd7, d);
    chk("R10 no write when ce low", d, pat(SALT0, 7));
  endtask

  task automatic t_no_strobe;
    logic [31:0] d;
    @(negedge clk_i);
    top_fuse_en_i = 1'b1; top_fuse_addr_i = 6'd0;
    bot_fuse_en_i = 1'b1; bot_fuse_addr_i = 6'd0;
    for (int i = 0; i < 3; i++) begin
      rd(mk(0, i), d);
      chk("R9 top fuse ignored", d, pat(SALT0, mk(0, i)));
      rd(mk(1, i), d);
      chk("R9 bottom fuse ignored", d, pat(SALT0, mk(1, i)));
    end
    top_fuse_en_i = 1'b0; bot_fuse_en_i = 1'b0;
  endtask

  task automatic t_shift;
    logic [31:0] d;
    load_fuse(1'b1, 10, 1'b0, 0);
    for (int i = 0; i < 64; i++) begin
      rd(mk(0, i), d);
      if (i < 10)      chk("R5 below fault", d, pat(SALT0, mk(0, i)));
      else if (i < 63) chk("R6 shifted", d, pat(SALT0, mk(0, i + 1)));
      else             chk("R6 top idx to spare", d, 32'h0);
      rd(mk(1, i), d);
      chk("R8 other bank unshifted", d, pat(SALT0, mk(1, i)));
    end
  endtask

  task automatic t_edges;
    logic [31:0] d;
    load_fuse(1'b1, 0, 1'b1, 63);
    for (int i = 0; i < 64; i++) begin
      rd(mk(0, i), d);
      chk("R6 fuse at 0 shifts all", d, (i < 63) ? pat(SALT0, mk(0, i + 1)) : 32'h0);
      rd(mk(1, i), d);
      chk("R5/R6 fuse at 63", d, (i < 63) ? pat(SALT0, mk(1, i)) : 32'h0);
    end
  endtask

  task automatic t_repaired_use;
    logic [31:0] d;
    load_fuse(1'b1, 0, 1'b1, 63);
    for (int a = 0; a < 128; a++) wr(a[6:0], pat(SALT1, a));
    for (int a = 0; a < 128; a++) begin
      rd(a[6:0], d);
      chk("R5/R6 full use with repair", d, pat(SALT1, a));
    end
    load_fuse(1'b0, 0, 1'b0, 0);
    rd(mk(0, 0), d);
    chk("R7 faulty top row untouched", d, pat(SALT0, mk(0, 0)));
    rd(mk(1, 63), d);
    chk("R7 faulty bottom row untouched", d, pat(SALT0, mk(1, 63)));
    rd(mk(0, 1), d);
    chk("R4 repair off restores direct map", d, pat(SALT1, mk(0, 0)));
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 rdata after release", rdata_o, 32'h0);
    t_plain();
    t_latency();
    t_ce_ignored();
    t_no_strobe();
    t_shift();
    t_edges();
    t_repaired_use();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule